// File: doc/BRIEF.md
# Mapped Interrupt Concentrator

The concentrator gathers 64 level-sensitive interrupt lines into a single outstanding vector request. Lines 0 to 31 form the lower bank. They are gated in groups of four, so there are eight shared mapping registers. Lines 32 to 63 form the upper bank, and each of these lines has a mapping register of its own. Bit 31 of every mapping register is its enable. The remaining 31 bits are fixed identification fields that software can read but cannot change.

Only one request is held at a time, and the `ivec_req` output shows it as one asserted bit. A rising lower-bank line preempts whatever is outstanding. A rising upper-bank line is taken only when nothing is outstanding. The request stays until software withdraws it, either through a clear register or by disabling the mapping register that governs it. Every register write then triggers a priority rescan of the lines that are currently asserted.

Software reaches the registers through a simple 32-bit port. Writes are synchronous and reads are combinational. Each register sits in a 64-bit slot, and only the upper word of the slot (address bit 2 = 1) holds data.

Top module: `ivc_concentrator`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable bit is cleared, the latched line levels are cleared and no request is held, so `ivec_req` reads 0 after that edge.
- R2: Register slots are 8 bytes wide. Group mapping register k (0..7) is at 0x0C00+8k, line mapping register j (0..31) is at 0x1000+8j, group clear register k is at 0x1400+8k and line clear register j is at 0x1800+8j. Only the word with address bit 2 set holds data. The word with bit 2 clear reads 0 and ignores writes, and the clear registers also read 0.
- R3: A mapping write changes only bit 31 (the enable), and bits 30..0 always read a fixed value. That value is 0x7C0 | (k<<2) for group register k and 0x7E0 + j for line register j.
- R4: `ivec_req` has at most one bit set, namely the bit of the held request's line index. It changes on the clock edge that samples its cause and is otherwise held.
- R5: When a lower line i (0..31) rises and its group register i/4 is enabled, line i becomes the request at that edge and replaces any held request. If several such lines rise together, the lowest index wins.
- R6: A rising upper line 32+j becomes the request only if no request is held after that cycle's register write and line register j is enabled. If several rise together, the lowest index wins.
- R7: Deasserting a line never withdraws a held request.
- R8: A mapping write with bit 31 = 0 withdraws the held request if that register governs it. A write with bit 31 = 1 never withdraws one.
- R9: Writing group clear k withdraws a request on lines 4k..4k+3, and writing line clear j withdraws a request on line 32+j. A clear that names any other line has no effect.
- R10: After any data-word write to a mapping or clear register, if no request remains, the lowest-indexed asserted line whose enable is set becomes the request, so the lower bank is considered before the upper bank. Without a write, a line that stays high is never picked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 64 | Level-sensitive interrupt lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| ivec_req | output | 64 | One-hot pending request vector |

## Verification
The directed scenarios target the asymmetry between the two banks. A lower line must preempt a held upper request, while an upper line must wait. A design that treats both banks alike would either lose the preemption or let an upper line steal the slot. The scenarios also test clears and disabling writes that name the wrong register, which must leave the request alone, and rescans that must pick a lower line ahead of an asserted upper one. A rescan must also re-request a line that is still high after its own clear. Two further checks guard the mapping registers. Writes to the low word must not change any enable, and the fixed fields must survive writes of all ones. A design that lets a falling line drop the request, or that rescans without a write, fails the hold checks.

// File: rtl/ivc_pkg.sv
// Shared sizes and register layout for the interrupt concentrator.
// Assumes both banks hold a power-of-two number of lines.
package ivc_pkg;
    localparam int LO_LINES  = 32;
    localparam int GRP_SIZE  = 4;
    localparam int HI_LINES  = 32;
    localparam int GRP_CNT   = LO_LINES / GRP_SIZE;
    localparam int ALL_LINES = LO_LINES + HI_LINES;
    localparam int IDX_W     = $clog2(ALL_LINES);
    localparam int GRP_W     = $clog2(GRP_CNT);
    localparam int GRP_SH    = $clog2(GRP_SIZE);
    localparam int SOLO_W    = $clog2(HI_LINES);
    localparam int SLOT_SH   = 3;

    localparam logic [15:0] GRP_MAP_BASE  = 16'h0C00;
    localparam logic [15:0] SOLO_MAP_BASE = 16'h1000;
    localparam logic [15:0] GRP_CLR_BASE  = 16'h1400;
    localparam logic [15:0] SOLO_CLR_BASE = 16'h1800;
    localparam logic [15:0] GRP_SPAN      = 16'(GRP_CNT << SLOT_SH);
    localparam logic [15:0] SOLO_SPAN     = 16'(HI_LINES << SLOT_SH);

    localparam logic [30:0] GRP_FIXED  = 31'h7C0;
    localparam logic [30:0] SOLO_FIXED = 31'h7E0;
endpackage

// File: rtl/ivc_first_set.sv
// Finds the lowest set bit of a vector.
// Purely combinational; idx is 0 when nothing is set.
module ivc_first_set #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest hit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ivc_cfg_regs.sv
// Register port: address decode, enable storage, read mux and write events.
// Assumes the data word of each slot is at address bit 2 = 1; bits 1:0 ignored.
module ivc_cfg_regs
    import ivc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         addr,
    input  logic                wr_enable_bit,
    output logic [31:0]         rdata,
    output logic [GRP_CNT-1:0]  grp_en_d,
    output logic [HI_LINES-1:0] solo_en_d,
    output logic                ev_rescan,
    output logic                ev_grp_hit,
    output logic [GRP_W-1:0]    ev_grp_idx,
    output logic                ev_solo_hit,
    output logic [SOLO_W-1:0]   ev_solo_idx
);
    logic [GRP_CNT-1:0]  grp_en_q;
    logic [HI_LINES-1:0] solo_en_q;
    logic [15:0] off_gm, off_sm, off_gc, off_sc;
    logic in_gm, in_sm, in_gc, in_sc, wr_data;
    logic [GRP_W-1:0]  gm_idx, gc_idx;
    logic [SOLO_W-1:0] sm_idx, sc_idx;

    // Decode which register window the address falls into.
    always_comb begin
        off_gm = addr - GRP_MAP_BASE;
        off_sm = addr - SOLO_MAP_BASE;
        off_gc = addr - GRP_CLR_BASE;
        off_sc = addr - SOLO_CLR_BASE;
        in_gm  = (addr >= GRP_MAP_BASE)  && (off_gm < GRP_SPAN);
        in_sm  = (addr >= SOLO_MAP_BASE) && (off_sm < SOLO_SPAN);
        in_gc  = (addr >= GRP_CLR_BASE)  && (off_gc < GRP_SPAN);
        in_sc  = (addr >= SOLO_CLR_BASE) && (off_sc < SOLO_SPAN);
        gm_idx = off_gm[SLOT_SH +: GRP_W];
        gc_idx = off_gc[SLOT_SH +: GRP_W];
        sm_idx = off_sm[SLOT_SH +: SOLO_W];
        sc_idx = off_sc[SLOT_SH +: SOLO_W];
        wr_data = wr_en && addr[2];
    end

    // Next enable state: a data-word mapping write replaces only the enable.
    always_comb begin
        grp_en_d  = grp_en_q;
        solo_en_d = solo_en_q;
        if (wr_data && in_gm) grp_en_d[gm_idx]  = wr_enable_bit;
        if (wr_data && in_sm) solo_en_d[sm_idx] = wr_enable_bit;
    end

    // Events handed to the request controller.
    always_comb begin
        ev_rescan   = wr_data && (in_gm || in_sm || in_gc || in_sc);
        ev_grp_hit  = wr_data && ((in_gm && !wr_enable_bit) || in_gc);
        ev_grp_idx  = in_gm ? gm_idx : gc_idx;
        ev_solo_hit = wr_data && ((in_sm && !wr_enable_bit) || in_sc);
        ev_solo_idx = in_sm ? sm_idx : sc_idx;
    end

    // Enable storage; reset disables every mapping register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_en_q  <= '0;
            solo_en_q <= '0;
        end else begin
            grp_en_q  <= grp_en_d;
            solo_en_q <= solo_en_d;
        end
    end

    // Read mux: enable bit over the fixed field, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr[2]) begin
            if (in_gm)
                rdata = {grp_en_q[gm_idx], GRP_FIXED | (31'(gm_idx) << GRP_SH)};
            else if (in_sm)
                rdata = {solo_en_q[sm_idx], SOLO_FIXED + 31'(sm_idx)};
        end
    end

    AST_EN_CLEARED_BY_RESET: assert property (@(posedge clk)
        !rst_n |=> (grp_en_q == '0 && solo_en_q == '0)); // R1
    AST_LOW_WORD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[2] |-> rdata == 32'h0); // R2
    AST_LOW_WORD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[2]) |=> (grp_en_q == $past(grp_en_q) && solo_en_q == $past(solo_en_q))); // R2
endmodule

// File: rtl/ivc_req_ctrl.sv
// Holds the single outstanding request, detects rising lines and rescans.
// Assumes register events arrive in the same cycle as the write strobe.
module ivc_req_ctrl
    import ivc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ALL_LINES-1:0] lines,
    input  logic [GRP_CNT-1:0]   grp_en_d,
    input  logic [HI_LINES-1:0]  solo_en_d,
    input  logic                 ev_rescan,
    input  logic                 ev_grp_hit,
    input  logic [GRP_W-1:0]     ev_grp_idx,
    input  logic                 ev_solo_hit,
    input  logic [SOLO_W-1:0]    ev_solo_idx,
    output logic [ALL_LINES-1:0] req_vec
);
    logic [ALL_LINES-1:0] line_q, en_mask, rise;
    logic                 req_valid_q, req_valid_d, kill;
    logic [IDX_W-1:0]     req_idx_q, req_idx_d, scan_idx;
    logic [GRP_W+GRP_SH-1:0] lo_idx;
    logic [SOLO_W-1:0]    hi_idx;
    logic                 scan_found, lo_found, hi_found;

    // Per-line enable: shared group bit for the lower bank, own bit above.
    for (genvar i = 0; i < LO_LINES; i++) begin : g_lo_en
        assign en_mask[i] = grp_en_d[i / GRP_SIZE];
    end
    for (genvar j = 0; j < HI_LINES; j++) begin : g_hi_en
        assign en_mask[LO_LINES + j] = solo_en_d[j];
    end

    assign rise = lines & ~line_q;

    ivc_first_set #(.W(ALL_LINES)) u_scan (
        .vec(lines & en_mask), .found(scan_found), .idx(scan_idx));
    ivc_first_set #(.W(LO_LINES)) u_lo (
        .vec(rise[LO_LINES-1:0] & en_mask[LO_LINES-1:0]), .found(lo_found), .idx(lo_idx));
    ivc_first_set #(.W(HI_LINES)) u_hi (
        .vec(rise[ALL_LINES-1:LO_LINES] & en_mask[ALL_LINES-1:LO_LINES]),
        .found(hi_found), .idx(hi_idx));

    // Withdraw on a matching clear/disable, rescan, then apply rising lines.
    always_comb begin
        kill = req_valid_q &&
               ((ev_grp_hit && req_idx_q < IDX_W'(LO_LINES) &&
                 req_idx_q[GRP_SH +: GRP_W] == ev_grp_idx) ||
                (ev_solo_hit && req_idx_q >= IDX_W'(LO_LINES) &&
                 req_idx_q[SOLO_W-1:0] == ev_solo_idx));
        req_valid_d = req_valid_q && !kill;
        req_idx_d   = req_idx_q;
        if (ev_rescan && !req_valid_d && scan_found) begin
            req_valid_d = 1'b1;
            req_idx_d   = scan_idx;
        end
        if (lo_found) begin
            req_valid_d = 1'b1;
            req_idx_d   = IDX_W'(lo_idx);
        end else if (!req_valid_d && hi_found) begin
            req_valid_d = 1'b1;
            req_idx_d   = IDX_W'(LO_LINES) + IDX_W'(hi_idx);
        end
    end

    // Request and line-level state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q      <= '0;
            req_valid_q <= 1'b0;
            req_idx_q   <= '0;
        end else begin
            line_q      <= lines;
            req_valid_q <= req_valid_d;
            req_idx_q   <= req_idx_d;
        end
    end

    // One-hot view of the held request.
    assign req_vec = req_valid_q ? (ALL_LINES'(1) << req_idx_q) : '0;

    AST_REQ_CLEARED_BY_RESET: assert property (@(posedge clk)
        !rst_n |=> !req_valid_q); // R1
    AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec)); // R4
    AST_LOWER_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
        lo_found |=> (req_valid_q && req_idx_q == IDX_W'($past(lo_idx)))); // R5
    AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_q && hi_found && !lo_found && !ev_rescan) |=> $stable(req_idx_q)); // R6
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_q && !lo_found && !ev_rescan) |=> (req_valid_q && $stable(req_idx_q))); // R7
    AST_WITHDRAW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !scan_found && !lo_found) |=> !req_valid_q); // R8
endmodule

// File: rtl/ivc_concentrator.sv
// Top of the mapped interrupt concentrator: register port plus request control.
// Assumes synchronous active-low reset and inputs stable around the clock edge.
module ivc_concentrator
    import ivc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ALL_LINES-1:0] irq_lines,
    input  logic                 cfg_wr,
    input  logic [15:0]          cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic [ALL_LINES-1:0] ivec_req
);
    logic [GRP_CNT-1:0]  grp_en_d;
    logic [HI_LINES-1:0] solo_en_d;
    logic                ev_rescan, ev_grp_hit, ev_solo_hit;
    logic [GRP_W-1:0]    ev_grp_idx;
    logic [SOLO_W-1:0]   ev_solo_idx;

    ivc_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wr_enable_bit(cfg_wdata[31]), .rdata(cfg_rdata),
        .grp_en_d(grp_en_d), .solo_en_d(solo_en_d),
        .ev_rescan(ev_rescan), .ev_grp_hit(ev_grp_hit), .ev_grp_idx(ev_grp_idx),
        .ev_solo_hit(ev_solo_hit), .ev_solo_idx(ev_solo_idx));

    ivc_req_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines),
        .grp_en_d(grp_en_d), .solo_en_d(solo_en_d),
        .ev_rescan(ev_rescan), .ev_grp_hit(ev_grp_hit), .ev_grp_idx(ev_grp_idx),
        .ev_solo_hit(ev_solo_hit), .ev_solo_idx(ev_solo_idx),
        .req_vec(ivec_req));
endmodule

// File: tb/ivc_concentrator_test.sv
`timescale 1ns/1ps
module ivc_concentrator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] ivec_req;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    ivc_concentrator uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ivec_req(ivec_req));

    always #4 clk = ~clk;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc();
        cfg_wr = 1'b0; cfg_addr = '0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        chk({32'h0, cfg_rdata}, {32'h0, exp}, tag);
        cfg_addr = '0;
    endtask

    task automatic set_line(input int i, input logic v);
        irq_lines[i] = v;
        cyc();
    endtask

    function automatic logic [63:0] bitv(input int i);
        return 64'h1 << i;
    endfunction

    task automatic t_reset();
        repeat (3) cyc();
        chk(ivec_req, 64'h0, "R1 no request in reset");
        rst_n = 1'b1;
        cyc();
        chk(ivec_req, 64'h0, "R1 idle after reset");
    endtask

    task automatic t_defaults();
        rd_chk(16'h0C04, 32'h000007C0, "R3 group 0 fixed field");
        rd_chk(16'h0C3C, 32'h000007DC, "R3 group 7 fixed field");
        rd_chk(16'h1004, 32'h000007E0, "R3 line reg 0 fixed field");
        rd_chk(16'h1014, 32'h000007E2, "R3 line reg 2 fixed field");
        rd_chk(16'h10FC, 32'h000007FF, "R3 line reg 31 fixed field");
        rd_chk(16'h1404, 32'h0, "R2 clear register reads zero");
    endtask

    task automatic t_words();
        wr(16'h0C08, 32'h80000000);
        rd_chk(16'h0C0C, 32'h000007C4, "R2 low word write ignored");
        rd_chk(16'h0C00, 32'h0, "R2 low word reads zero");
        wr(16'h0C04, 32'hFFFFFFFF);
        rd_chk(16'h0C04, 32'h800007C0, "R3 only enable bit written");
        wr(16'h0C04, 32'h00000000);
        rd_chk(16'h0C04, 32'h000007C0, "R3 enable cleared");
        wr(16'h0C04, 32'h80000000);
        wr(16'h100C, 32'h80001234);
        rd_chk(16'h100C, 32'h800007E1, "R3 line reg keeps fixed field");
    endtask

    task automatic t_lower_rise();
        set_line(2, 1'b1);
        chk(ivec_req, bitv(2), "R5 lower rise requested");
        set_line(33, 1'b1);
        chk(ivec_req, bitv(2), "R6 upper rise waits");
        set_line(2, 1'b0);
        chk(ivec_req, bitv(2), "R7 falling line keeps request");
    endtask

    task automatic t_clears();
        wr(16'h140C, 32'h0);
        chk(ivec_req, bitv(2), "R9 other group clear ignored");
        wr(16'h1404, 32'h0);
        chk(ivec_req, bitv(33), "R9 R10 group clear then rescan");
        wr(16'h1804, 32'h0);
        chk(ivec_req, bitv(33), "R9 other line clear ignored");
    endtask

    task automatic t_preempt();
        wr(16'h0C14, 32'h80000000);
        chk(ivec_req, bitv(33), "R10 rescan keeps held request");
        irq_lines[10] = 1'b1;
        irq_lines[9]  = 1'b1;
        cyc();
        chk(ivec_req, bitv(9), "R5 lowest of two lower rises");
        set_line(8, 1'b1);
        chk(ivec_req, bitv(8), "R5 new lower rise replaces");
    endtask

    task automatic t_disable();
        wr(16'h0C14, 32'h0);
        chk(ivec_req, bitv(33), "R8 disable withdraws, rescan finds 33");
        wr(16'h100C, 32'h7FFFFFFF);
        chk(ivec_req, 64'h0, "R8 disable withdraws, nothing left");
        rd_chk(16'h100C, 32'h000007E1, "R3 disable keeps fixed field");
    endtask

    task automatic t_upper();
        wr(16'h102C, 32'h80000000);
        chk(ivec_req, 64'h0, "R10 rescan with nothing asserted");
        set_line(37, 1'b1);
        chk(ivec_req, bitv(37), "R6 upper rise when idle");
        wr(16'h182C, 32'h0);
        chk(ivec_req, bitv(37), "R10 cleared line still high re-requested");
        set_line(37, 1'b0);
        wr(16'h182C, 32'h0);
        chk(ivec_req, 64'h0, "R9 line clear withdraws");
        wr(16'h1034, 32'h80000000);
        wr(16'h103C, 32'h80000000);
        irq_lines[39] = 1'b1;
        irq_lines[38] = 1'b1;
        cyc();
        chk(ivec_req, bitv(38), "R6 lowest of two upper rises");
        set_line(38, 1'b0);
        chk(ivec_req, bitv(38), "R7 upper falling keeps request");
        wr(16'h1834, 32'h0);
        chk(ivec_req, bitv(39), "R10 rescan picks remaining upper");
        set_line(39, 1'b0);
        wr(16'h183C, 32'h0);
        chk(ivec_req, 64'h0, "R9 line clear empties");
    endtask

    task automatic t_order();
        set_line(40, 1'b1);
        chk(ivec_req, 64'h0, "R6 disabled upper rise ignored");
        wr(16'h1044, 32'h80000000);
        chk(ivec_req, bitv(40), "R10 enable write rescans");
        wr(16'h0C14, 32'h80000000);
        chk(ivec_req, bitv(40), "R8 enabling write keeps request");
        wr(16'h1844, 32'h0);
        chk(ivec_req, bitv(8), "R10 lower bank before upper");
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        cyc();
        chk(ivec_req, 64'h0, "R1 reset drops request");
        rd_chk(16'h0C14, 32'h000007C8, "R1 reset clears enable");
        rst_n = 1'b1;
        cyc();
        chk(ivec_req, 64'h0, "R1 disabled lines stay quiet");
        irq_lines = '0;
        cyc();
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_words();
        t_lower_rise();
        t_clears();
        t_preempt();
        t_disable();
        t_upper();
        t_order();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule